// File: doc/BRIEF.md
# Interrupt-capable GPIO bank controller

This block controls one bank of general-purpose pins through a small memory-mapped register port. It has a byte address, write data, a write strobe, a read strobe and read data. Each pin has its own output value and its own output enable, and each pin has a pull-resistor setting that goes to the pad controls. The pin inputs pass through a synchronizer. Software can read the synchronized values back.

Every pin can watch its input for a rising edge, a falling edge, either edge, a high level or a low level. Three independent per-pin bits select the trigger:

- a sense bit picks level or edge;
- a both-edges bit;
- a polarity bit.

Detected events set a sticky raw status bit. A per-pin enable mask gates the raw status into a masked status. The OR of the masked bits drives a single registered interrupt line. Software acknowledges events by writing ones to a clear register.

Top module: `pin_bank_ctrl`

## Requirements
- R1: After reset every register reads 0. The outputs padOut, padOe, padPullUp, padPullDn and irqOut are all 0.
- R2: Writes to the output-value register (byte offset 0x04) and the output-enable register (0x08) read back unchanged. The same holds for the sense (0x0C), both-edges (0x10), polarity (0x14), mask (0x18), pull-direction (0x34) and pull-enable (0x38) registers. Bit n of every register belongs to pin n. padOut mirrors 0x04 and padOe mirrors 0x08.
- R3: The input register (0x00) shows padIn through a two-stage synchronizer. A read that is captured on the third rising edge after padIn changes returns the new value. Reads captured on the first or second such edge return the old value.
- R4: With sense bit 0 (edge) and both-edges bit 0, polarity 1 latches raw status on a 0-to-1 input transition and polarity 0 latches it on a 1-to-0 transition. A pin with no transition latches nothing.
- R5: With sense bit 0 and both-edges bit 1, either transition latches raw status, whatever the polarity bit holds.
- R6: With sense bit 1 (level), raw status is set on every cycle that the input equals the polarity bit. A clear therefore has no lasting effect until the level goes inactive, and the bit stays set after the level goes away.
- R7: Masked status (0x20) equals raw status (0x1C) ANDed with the mask, where a mask bit of 1 enables the pin. irqOut is the registered OR of the masked status, and it is 0 whenever the mask was all zero on the previous cycle.
- R8: Writing the clear register (0x24) clears each raw status bit written with 1 and leaves bits written with 0 alone. Raw status bits fall only through such a write. A read of 0x24 returns 0.
- R9: When a pin's pull-enable bit is 0, both padPullUp and padPullDn are 0 for that pin. When it is 1, pull-direction 1 raises padPullUp and pull-direction 0 raises padPullDn.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 8 | Byte address of the register access |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe; busRdata is valid after the next rising edge |
| busRdata | output | 32 | Registered read data |
| padIn | input | 32 | Asynchronous pin inputs |
| padOut | output | 32 | Per-pin output value |
| padOe | output | 32 | Per-pin output enable |
| padPullUp | output | 32 | Per-pin pull-up enable |
| padPullDn | output | 32 | Per-pin pull-down enable |
| irqOut | output | 1 | Combined interrupt, registered |

## Verification
The embedded assertions check these rules on every cycle:

- a raw status bit only falls through a clear write;
- in edge mode, a new status bit never appears without a transition on the synchronized input;
- in level mode, an active level always leaves its status bit set;
- the interrupt stays low after a cycle with an all-zero mask;
- the output enables hold between writes;
- a read of the clear register returns 0.

Only the bench scenarios can show the rest. They show that each of the five trigger settings latches exactly the transitions it should on a randomly chosen pin. They also show the exact synchronizer latency on readback, that a clear of an active level is overridden, and that the masked view and the interrupt follow the mask.

// File: rtl/pbk_pkg.sv
package pbk_pkg;

  // Byte offsets; software decodes these, so they are fixed.
  localparam int OFF_DIN   = 'h00;
  localparam int OFF_DOUT  = 'h04;
  localparam int OFF_OE    = 'h08;
  localparam int OFF_SENSE = 'h0C;
  localparam int OFF_BOTH  = 'h10;
  localparam int OFF_POL   = 'h14;
  localparam int OFF_MASK  = 'h18;
  localparam int OFF_RAW   = 'h1C;
  localparam int OFF_MSKD  = 'h20;
  localparam int OFF_CLR   = 'h24;
  localparam int OFF_PDIR  = 'h34;
  localparam int OFF_PEN   = 'h38;

  typedef enum logic [3:0] {
    RD_ZERO, RD_DIN, RD_DOUT, RD_OE, RD_SENSE, RD_BOTH, RD_POL,
    RD_MASK, RD_RAW, RD_MSKD, RD_PDIR, RD_PEN
  } rdSel_e;

  typedef struct packed {
    logic   wrDout;
    logic   wrOe;
    logic   wrSense;
    logic   wrBoth;
    logic   wrPol;
    logic   wrMask;
    logic   wrClr;
    logic   wrPdir;
    logic   wrPen;
    logic   rdEn;
    rdSel_e rdSel;
  } busStrobe_t;

endpackage

// File: rtl/pbk_trigger.sv
module pbk_trigger (
  input  logic cur,
  input  logic prev,
  input  logic isLevel,
  input  logic isBoth,
  input  logic isRise,
  output logic hit
);
  logic rise;
  logic fall;

  assign rise = cur & ~prev;
  assign fall = ~cur & prev;

  always_comb begin
    if (isLevel)     hit = (cur == isRise);
    else if (isBoth) hit = rise | fall;
    else if (isRise) hit = rise;
    else             hit = fall;
  end
endmodule

// File: rtl/pbk_ctrl.sv
module pbk_ctrl
  import pbk_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              busWe,
  input  logic              busRe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobe_t        strobe
);
  always_comb begin
    strobe       = '0;
    strobe.rdEn  = busRe;
    strobe.rdSel = RD_ZERO;
    case (busAddr)
      ADDR_W'(OFF_DIN):   strobe.rdSel = RD_DIN;
      ADDR_W'(OFF_DOUT):  begin strobe.rdSel = RD_DOUT;  strobe.wrDout  = busWe; end
      ADDR_W'(OFF_OE):    begin strobe.rdSel = RD_OE;    strobe.wrOe    = busWe; end
      ADDR_W'(OFF_SENSE): begin strobe.rdSel = RD_SENSE; strobe.wrSense = busWe; end
      ADDR_W'(OFF_BOTH):  begin strobe.rdSel = RD_BOTH;  strobe.wrBoth  = busWe; end
      ADDR_W'(OFF_POL):   begin strobe.rdSel = RD_POL;   strobe.wrPol   = busWe; end
      ADDR_W'(OFF_MASK):  begin strobe.rdSel = RD_MASK;  strobe.wrMask  = busWe; end
      ADDR_W'(OFF_RAW):   strobe.rdSel = RD_RAW;
      ADDR_W'(OFF_MSKD):  strobe.rdSel = RD_MSKD;
      ADDR_W'(OFF_CLR):   strobe.wrClr = busWe;
      ADDR_W'(OFF_PDIR):  begin strobe.rdSel = RD_PDIR;  strobe.wrPdir  = busWe; end
      ADDR_W'(OFF_PEN):   begin strobe.rdSel = RD_PEN;   strobe.wrPen   = busWe; end
      default: ;
    endcase
  end
endmodule

// File: rtl/pbk_datapath.sv
module pbk_datapath
  import pbk_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  busStrobe_t           strobe,
  input  logic [PIN_COUNT-1:0] busWdata,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] padPullDn,
  output logic                 irqOut
);
  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [PIN_COUNT-1:0] doutQ, oeQ, senseQ, bothQ, polQ, maskQ, pdirQ, penQ;
  logic [PIN_COUNT-1:0] rawQ, prevQ, curIn, hitVec, clrBits, maskedStat;
  logic [PIN_COUNT-1:0] syncQ [SYNC_STAGES];
  logic [PIN_COUNT-1:0] rdMux;
  logic                 irqQ;

  // Input synchronizer plus history flop for transition detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncQ[s] <= '0;
      prevQ <= '0;
    end else begin
      syncQ[0] <= padIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncQ[s] <= syncQ[s-1];
      prevQ <= syncQ[LAST_STAGE];
    end
  end

  assign curIn = syncQ[LAST_STAGE];

  for (genvar gi = 0; gi < PIN_COUNT; gi++) begin : g_pin
    pbk_trigger trig_i (
      .cur     (curIn[gi]),
      .prev    (prevQ[gi]),
      .isLevel (senseQ[gi]),
      .isBoth  (bothQ[gi]),
      .isRise  (polQ[gi]),
      .hit     (hitVec[gi])
    );
  end

  assign clrBits    = strobe.wrClr ? busWdata : '0;
  assign maskedStat = rawQ & maskQ;

  // Configuration registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doutQ <= '0; oeQ <= '0; senseQ <= '0; bothQ <= '0;
      polQ  <= '0; maskQ <= '0; pdirQ <= '0; penQ <= '0;
    end else begin
      if (strobe.wrDout)  doutQ  <= busWdata;
      if (strobe.wrOe)    oeQ    <= busWdata;
      if (strobe.wrSense) senseQ <= busWdata;
      if (strobe.wrBoth)  bothQ  <= busWdata;
      if (strobe.wrPol)   polQ   <= busWdata;
      if (strobe.wrMask)  maskQ  <= busWdata;
      if (strobe.wrPdir)  pdirQ  <= busWdata;
      if (strobe.wrPen)   penQ   <= busWdata;
    end
  end

  // Sticky status: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rawQ <= '0;
      irqQ <= 1'b0;
    end else begin
      rawQ <= (rawQ & ~clrBits) | hitVec;
      irqQ <= |maskedStat;
    end
  end

  always_comb begin
    case (strobe.rdSel)
      RD_DIN:   rdMux = curIn;
      RD_DOUT:  rdMux = doutQ;
      RD_OE:    rdMux = oeQ;
      RD_SENSE: rdMux = senseQ;
      RD_BOTH:  rdMux = bothQ;
      RD_POL:   rdMux = polQ;
      RD_MASK:  rdMux = maskQ;
      RD_RAW:   rdMux = rawQ;
      RD_MSKD:  rdMux = maskedStat;
      RD_PDIR:  rdMux = pdirQ;
      RD_PEN:   rdMux = penQ;
      default:  rdMux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN)            busRdata <= '0;
    else if (strobe.rdEn) busRdata <= rdMux;
  end

  assign padOut    = doutQ;
  assign padOe     = oeQ;
  assign padPullUp = penQ & pdirQ;
  assign padPullDn = penQ & ~pdirQ;
  assign irqOut    = irqQ;

  AST_RAW_FALLS_ONLY_ON_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rawQ) & ~rawQ & ~$past(clrBits)) == '0); // R8
  AST_EDGE_NEEDS_TRANSITION: assert property (@(posedge clk) disable iff (!rstN)
    (~$past(rawQ) & rawQ & ~$past(senseQ) & ~($past(curIn) ^ $past(prevQ))) == '0); // R4
  AST_LEVEL_KEEPS_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    ($past(senseQ) & ~($past(curIn) ^ $past(polQ)) & ~rawQ) == '0); // R6
  AST_IRQ_QUIET_WHEN_MASKED: assert property (@(posedge clk) disable iff (!rstN)
    ($past(maskQ) == '0) |-> !irqOut); // R7
endmodule

// File: rtl/pin_bank_ctrl.sv
module pin_bank_ctrl
  import pbk_pkg::*;
#(
  parameter int PIN_COUNT   = 32,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic [PIN_COUNT-1:0] busWdata,
  input  logic                 busWe,
  input  logic                 busRe,
  output logic [PIN_COUNT-1:0] busRdata,
  input  logic [PIN_COUNT-1:0] padIn,
  output logic [PIN_COUNT-1:0] padOut,
  output logic [PIN_COUNT-1:0] padOe,
  output logic [PIN_COUNT-1:0] padPullUp,
  output logic [PIN_COUNT-1:0] padPullDn,
  output logic                 irqOut
);
  busStrobe_t strobe;

  pbk_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .busWe   (busWe),
    .busRe   (busRe),
    .busAddr (busAddr),
    .strobe  (strobe)
  );

  pbk_datapath #(.PIN_COUNT(PIN_COUNT), .SYNC_STAGES(SYNC_STAGES)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .busRdata  (busRdata),
    .padIn     (padIn),
    .padOut    (padOut),
    .padOe     (padOe),
    .padPullUp (padPullUp),
    .padPullDn (padPullDn),
    .irqOut    (irqOut)
  );

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(OFF_CLR)) |=> (busRdata == '0)); // R8
  AST_OE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWe && busAddr == ADDR_W'(OFF_OE)) |-> $stable(padOe)); // R2
endmodule

// File: tb/pin_bank_ctrl_tb_top.sv
module pin_bank_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [7:0]    busAddr = '0;
  logic [N-1:0]  busWdata = '0;
  logic          busWe = 1'b0;
  logic          busRe = 1'b0;
  logic [N-1:0]  busRdata;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  padOut, padOe, padPullUp, padPullDn;
  logic          irqOut;

  int nChk = 0;
  int nBad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_bank_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWdata(busWdata),
    .busWe(busWe), .busRe(busRe), .busRdata(busRdata), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .padPullUp(padPullUp),
    .padPullDn(padPullDn), .irqOut(irqOut)
  );

  task automatic check(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [7:0] a, input logic [N-1:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk); @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busRead(input logic [7:0] a, output logic [N-1:0] d);
    busAddr = a; busRe = 1'b1;
    @(posedge clk); @(negedge clk);
    busRe = 1'b0; d = busRdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Expected raw status for one pin after a single old->new step,
  // with a clear issued while the old value was settled.
  function automatic logic expStatus(input logic lvl, input logic both, input logic pol,
                                     input logic oldV, input logic newV);
    if (lvl) return (oldV == pol) || (newV == pol);
    if (both) return oldV != newV;
    if (pol) return !oldV && newV;
    return oldV && !newV;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    nChk++; nBad++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end

  initial begin
    logic [N-1:0] rd, v, w;
    void'($urandom(32'd4242));
    idle(3);
    rstN = 1'b1;
    idle(1);

    // R1 reset state
    check("R1 padOut", padOut, '0);
    check("R1 padOe", padOe, '0);
    check("R1 pulls", padPullUp | padPullDn, '0);
    check("R1 irqOut", N'(irqOut), '0);
    foreach (rd[i]) ;
    for (int a = 0; a <= 'h38; a += 4) begin
      busRead(8'(a), rd);
      check("R1 register reads 0", rd, '0);
    end

    // R2 / R9 register readback and pad mirrors
    for (int k = 0; k < 8; k++) begin
      v = $urandom; w = $urandom;
      busWrite(8'h04, v); busWrite(8'h08, w);
      busRead(8'h04, rd); check("R2 dout readback", rd, v);
      busRead(8'h08, rd); check("R2 oe readback", rd, w);
      check("R2 padOut", padOut, v);
      check("R2 padOe", padOe, w);
      v = $urandom; w = $urandom;
      busWrite(8'h34, v); busWrite(8'h38, w);
      busRead(8'h34, rd); check("R2 pull-dir readback", rd, v);
      busRead(8'h38, rd); check("R2 pull-en readback", rd, w);
      check("R9 pull-up", padPullUp, w & v);
      check("R9 pull-down", padPullDn, w & ~v);
      v = $urandom;
      busWrite(8'h18, v); busRead(8'h18, rd); check("R2 mask readback", rd, v);
      v = $urandom;
      busWrite(8'h10, v); busRead(8'h10, rd); check("R2 both-edge readback", rd, v);
      busWrite(8'h10, '0);
      v = $urandom;
      busWrite(8'h14, v); busRead(8'h14, rd); check("R2 polarity readback", rd, v);
      busWrite(8'h14, '0);
    end
    busWrite(8'h0C, 32'h0000_0001); busRead(8'h0C, rd);
    check("R2 sense readback", rd, 32'h0000_0001);
    busWrite(8'h0C, '0); busWrite(8'h18, '0);
    idle(4);
    busWrite(8'h24, '1);
    busRead(8'h1C, rd); check("R8 clear all", rd, '0);

    // R3 synchronizer latency
    for (int k = 0; k < 4; k++) begin
      v = padIn; w = $urandom;
      padIn = w;
      busRead(8'h00, rd); check("R3 first edge old", rd, v);
      busRead(8'h00, rd); check("R3 second edge old", rd, v);
      busRead(8'h00, rd); check("R3 third edge new", rd, w);
    end
    padIn = '0;
    idle(4);
    busWrite(8'h24, '1);

    // R4 R5 R6 R7 random trigger trials on one pin
    for (int k = 0; k < 60; k++) begin
      int pin = int'($urandom % N);
      int mode = int'($urandom % 5);
      logic lvl, both, pol, oldV, newV, mk;
      logic [N-1:0] expRaw;
      lvl  = (mode >= 3);
      both = (mode == 2);
      pol  = (mode == 0 || mode == 3) ? 1'b1 : (mode == 2 ? 1'($urandom) : 1'b0);
      oldV = 1'($urandom); newV = 1'($urandom);
      mk   = 1'($urandom);
      busWrite(8'h0C, N'(lvl) << pin);
      busWrite(8'h10, N'(both) << pin);
      busWrite(8'h14, N'(pol) << pin);
      padIn = N'(oldV) << pin;
      idle(4);
      busWrite(8'h24, '1);
      padIn = N'(newV) << pin;
      idle(5);
      expRaw = N'(expStatus(lvl, both, pol, oldV, newV)) << pin;
      busRead(8'h1C, rd);
      if (lvl) check("R6 level status", rd, expRaw);
      else if (both) check("R5 both-edge status", rd, expRaw);
      else check("R4 edge status", rd, expRaw);
      busWrite(8'h18, N'(mk) << pin);
      busRead(8'h20, rd);
      check("R7 masked status", rd, expRaw & (N'(mk) << pin));
      idle(1);
      check("R7 irqOut", N'(irqOut), N'(|(expRaw & (N'(mk) << pin))));
      busWrite(8'h18, '0);
      busWrite(8'h0C, '0); busWrite(8'h10, '0); busWrite(8'h14, '0);
      padIn = '0;
      idle(4);
      busWrite(8'h24, '1);
    end

    // R6 directed: clear ignored while level stays active, sticky after
    busWrite(8'h0C, 32'h20); busWrite(8'h14, 32'h20);
    padIn = 32'h20;
    idle(4);
    busWrite(8'h24, 32'h20);
    busRead(8'h1C, rd); check("R6 clear overridden by active level", rd, 32'h20);
    padIn = '0;
    idle(4);
    busRead(8'h1C, rd); check("R6 status sticky after level drops", rd, 32'h20);
    busWrite(8'h24, 32'h20);
    busRead(8'h1C, rd); check("R6 clear after inactive", rd, '0);
    busWrite(8'h0C, '0); busWrite(8'h14, '0);

    // R8 partial clear and clear readback
    busWrite(8'h14, 32'h6);
    padIn = 32'h6;
    idle(4);
    busRead(8'h1C, rd); check("R4 two rising edges", rd, 32'h6);
    busWrite(8'h24, 32'h2);
    busRead(8'h1C, rd); check("R8 zero bits untouched", rd, 32'h4);
    busRead(8'h24, rd); check("R8 clear reads 0", rd, '0);
    busWrite(8'h18, 32'h4);
    idle(2);
    check("R7 irq raised by masked bit", N'(irqOut), 32'h1);
    busWrite(8'h24, 32'h4);
    idle(2);
    check("R7 irq drops after clear", N'(irqOut), 32'h0);

    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule